// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one processor's snooping cache and decides whether a store-conditional may complete. A load-linked arms a single reservation: a valid bit plus the block address it covers. While armed, the reservation watches every invalidation that the bus snooper delivers, and every replacement notice from the local cache. Any of these that names the reserved block disarms it. A later store-conditional succeeds only if the reservation is still armed and covers the same block.

Addresses are compared at cache-block granularity. The offset bits inside a block are masked off, and the block size is a parameter. Several snoop channels can be watched in parallel, also set by a parameter. The verdict for a store-conditional is produced in the cycle the request is presented, so the cache can commit or drop the store without an extra cycle. Whatever the verdict, the store-conditional consumes the reservation.

Top module: `llsc_resv_monitor`

## Requirements
- R1: After reset the reservation is disarmed, so a store-conditional issued before any load-linked reports failure.
- R2: A load-linked arms the reservation and records its block address (`ll_addr` with the low log2(BLOCK_BYTES) bits cleared).
- R3: Two addresses refer to the same block when they are equal after clearing the low log2(BLOCK_BYTES) bits. With the default BLOCK_BYTES=64, 0x1004 and 0x103C share a block and 0x1040 does not.
- R4: A store-conditional passes (`sc_pass`=1) only when the reservation is armed and `sc_addr` lies in the reserved block.
- R5: Every store-conditional, passing or failing, disarms the reservation from the next cycle on. A store-conditional to a block other than the reserved one fails.
- R6: A snoop invalidation on any channel i (`inv_valid[i]`=1, address in `inv_addr[i*ADDR_W +: ADDR_W]`) whose block matches the reserved block disarms the reservation. Invalidations to other blocks, or with the valid bit low, leave it armed.
- R7: When a matching invalidation arrives in the same cycle as a store-conditional to the reserved block, the invalidation wins and the store-conditional fails.
- R8: A local replacement notice (`evict_valid`=1) for the reserved block disarms the reservation. A notice for another block leaves it armed (default EVICT_BY_ADDR=1).
- R9: A load-linked replaces any earlier reservation. A store-conditional in the same cycle is judged against the old reservation, while the new one survives. A matching invalidation or replacement in the same cycle as the load-linked leaves the new reservation disarmed.
- R10: `sc_done` is high exactly in cycles where `sc_valid` is high, and `sc_pass` is low whenever `sc_done` is low. The verdict is combinational in the request cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ll_valid | input | 1 | Load-linked issued this cycle |
| ll_addr | input | ADDR_W | Load-linked byte address |
| sc_valid | input | 1 | Store-conditional issued this cycle |
| sc_addr | input | ADDR_W | Store-conditional byte address |
| inv_valid | input | NUM_SNOOP | Per-channel snoop invalidation valid |
| inv_addr | input | NUM_SNOOP*ADDR_W | Packed per-channel invalidation addresses, channel 0 in the low bits |
| evict_valid | input | 1 | Local cache replaced a block this cycle |
| evict_addr | input | ADDR_W | Address of the replaced block |
| sc_done | output | 1 | Store-conditional verdict is present |
| sc_pass | output | 1 | Store-conditional may complete |

## Verification
The verdict on `sc_done`/`sc_pass` depends only on inputs and the stored reservation, so it is due in the same cycle as `sc_valid`, with no register in between. Changes to the reservation made by a load-linked, a store-conditional, an invalidation or a replacement take effect at the next rising edge, so they first show in the verdict of the following cycle. The bench applies each operation for one cycle at the falling edge and samples the outputs one nanosecond later. It then reads the effect of earlier operations through a store-conditional placed in a later cycle, which keeps each check inside the cycle where its result is due.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

   typedef enum logic [1:0] {
      SC_IDLE = 2'b00,
      SC_FAIL = 2'b10,
      SC_PASS = 2'b11
   } sc_verdict_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int unsigned offset_bits(input int unsigned bytes);
      return $clog2(bytes);
   endfunction

endpackage

// File: rtl/llsc_blk_match.sv
module llsc_blk_match #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFF_W  = 6
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] ref_blk,
   output logic              hit
);
   localparam logic [ADDR_W-1:0] BLK_MASK = {{(ADDR_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};

   always_comb begin
      hit = en && ((addr & BLK_MASK) == ref_blk);
   end
endmodule

// File: rtl/llsc_kill_detect.sv
module llsc_kill_detect #(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned OFF_W         = 6,
   parameter int unsigned NUM_SNOOP     = 2,
   parameter bit          EVICT_BY_ADDR = 1'b1
) (
   input  logic [NUM_SNOOP-1:0]        inv_valid,
   input  logic [NUM_SNOOP*ADDR_W-1:0] inv_addr,
   input  logic                        evict_valid,
   input  logic [ADDR_W-1:0]           evict_addr,
   input  logic [ADDR_W-1:0]           ref_blk,
   output logic                        kill
);
   logic [NUM_SNOOP-1:0] port_hit;
   logic                 ev_hit;
   logic                 ev_kill;

   for (genvar gi = 0; gi < NUM_SNOOP; gi++) begin : g_port
      llsc_blk_match #(
         .ADDR_W (ADDR_W),
         .OFF_W  (OFF_W)
      ) u_cmp (
         .en      (inv_valid[gi]),
         .addr    (inv_addr[gi*ADDR_W +: ADDR_W]),
         .ref_blk (ref_blk),
         .hit     (port_hit[gi])
      );
   end

   llsc_blk_match #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W)
   ) u_ev_cmp (
      .en      (evict_valid),
      .addr    (evict_addr),
      .ref_blk (ref_blk),
      .hit     (ev_hit)
   );

   if (EVICT_BY_ADDR) begin : g_ev_addr
      assign ev_kill = ev_hit;
   end else begin : g_ev_any
      assign ev_kill = evict_valid | (ev_hit & 1'b0);
   end

   assign kill = (|port_hit) | ev_kill;
endmodule

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ll_valid,
   input  logic [ADDR_W-1:0] ll_blk,
   input  logic              ll_killed,
   input  logic              sc_valid,
   input  logic              lock_killed,
   output logic              flag,
   output logic [ADDR_W-1:0] blk
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
         blk  <= '0;
      end else if (ll_valid) begin
         flag <= !ll_killed;
         blk  <= ll_blk;
      end else if (sc_valid || lock_killed) begin
         flag <= 1'b0;
      end
   end
endmodule

// File: rtl/llsc_sc_judge.sv
module llsc_sc_judge #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFF_W  = 6
) (
   input  logic                     sc_valid,
   input  logic [ADDR_W-1:0]        sc_addr,
   input  logic                     flag,
   input  logic [ADDR_W-1:0]        blk,
   input  logic                     lock_killed,
   output llsc_pkg::sc_verdict_e    verdict
);
   logic same_blk;

   llsc_blk_match #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W)
   ) u_cmp (
      .en      (sc_valid),
      .addr    (sc_addr),
      .ref_blk (blk),
      .hit     (same_blk)
   );

   always_comb begin
      if (!sc_valid)
         verdict = llsc_pkg::SC_IDLE;
      else if (flag && same_blk && !lock_killed)
         verdict = llsc_pkg::SC_PASS;
      else
         verdict = llsc_pkg::SC_FAIL;
   end
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor #(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned BLOCK_BYTES   = 64,
   parameter int unsigned NUM_SNOOP     = 2,
   parameter bit          EVICT_BY_ADDR = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ll_valid,
   input  logic [ADDR_W-1:0]           ll_addr,
   input  logic                        sc_valid,
   input  logic [ADDR_W-1:0]           sc_addr,
   input  logic [NUM_SNOOP-1:0]        inv_valid,
   input  logic [NUM_SNOOP*ADDR_W-1:0] inv_addr,
   input  logic                        evict_valid,
   input  logic [ADDR_W-1:0]           evict_addr,
   output logic                        sc_done,
   output logic                        sc_pass
);
   localparam int unsigned OFF_W = llsc_pkg::offset_bits(BLOCK_BYTES);
   localparam logic [ADDR_W-1:0] BLK_MASK = {{(ADDR_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};

   if (!llsc_pkg::is_pow2(BLOCK_BYTES) || BLOCK_BYTES < 2) begin : g_bad_block
      $error("BLOCK_BYTES must be a power of two of at least 2");
   end
   if (OFF_W >= ADDR_W) begin : g_bad_width
      $error("ADDR_W must exceed the block offset width");
   end
   if (NUM_SNOOP < 1) begin : g_bad_snoop
      $error("NUM_SNOOP must be at least 1");
   end

   logic                  resv_flag;
   logic [ADDR_W-1:0]     resv_blk;
   logic [ADDR_W-1:0]     ll_blk;
   logic                  lock_killed;
   logic                  ll_killed;
   llsc_pkg::sc_verdict_e verdict;

   assign ll_blk = ll_addr & BLK_MASK;

   llsc_kill_detect #(
      .ADDR_W        (ADDR_W),
      .OFF_W         (OFF_W),
      .NUM_SNOOP     (NUM_SNOOP),
      .EVICT_BY_ADDR (EVICT_BY_ADDR)
   ) u_kill_lock (
      .inv_valid   (inv_valid),
      .inv_addr    (inv_addr),
      .evict_valid (evict_valid),
      .evict_addr  (evict_addr),
      .ref_blk     (resv_blk),
      .kill        (lock_killed)
   );

   llsc_kill_detect #(
      .ADDR_W        (ADDR_W),
      .OFF_W         (OFF_W),
      .NUM_SNOOP     (NUM_SNOOP),
      .EVICT_BY_ADDR (EVICT_BY_ADDR)
   ) u_kill_ll (
      .inv_valid   (inv_valid),
      .inv_addr    (inv_addr),
      .evict_valid (evict_valid),
      .evict_addr  (evict_addr),
      .ref_blk     (ll_blk),
      .kill        (ll_killed)
   );

   llsc_resv_reg #(
      .ADDR_W (ADDR_W)
   ) u_resv (
      .clk         (clk),
      .rst_n       (rst_n),
      .ll_valid    (ll_valid),
      .ll_blk      (ll_blk),
      .ll_killed   (ll_killed),
      .sc_valid    (sc_valid),
      .lock_killed (lock_killed),
      .flag        (resv_flag),
      .blk         (resv_blk)
   );

   llsc_sc_judge #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W)
   ) u_judge (
      .sc_valid    (sc_valid),
      .sc_addr     (sc_addr),
      .flag        (resv_flag),
      .blk         (resv_blk),
      .lock_killed (lock_killed),
      .verdict     (verdict)
   );

   assign sc_done = (verdict != llsc_pkg::SC_IDLE);
   assign sc_pass = (verdict == llsc_pkg::SC_PASS);
endmodule

// File: rtl/llsc_resv_checker.sv
module llsc_resv_checker #(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned BLOCK_BYTES   = 64,
   parameter int unsigned NUM_SNOOP     = 2,
   parameter bit          EVICT_BY_ADDR = 1'b1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        ll_valid,
   input logic [ADDR_W-1:0]           ll_addr,
   input logic                        sc_valid,
   input logic [ADDR_W-1:0]           sc_addr,
   input logic [NUM_SNOOP-1:0]        inv_valid,
   input logic [NUM_SNOOP*ADDR_W-1:0] inv_addr,
   input logic                        evict_valid,
   input logic [ADDR_W-1:0]           evict_addr,
   input logic                        sc_done,
   input logic                        sc_pass,
   input logic                        resv_flag,
   input logic [ADDR_W-1:0]           resv_blk
);
   localparam int unsigned OFF_W = $clog2(BLOCK_BYTES);
   localparam logic [ADDR_W-1:0] MSK = {{(ADDR_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};

   logic inv_hit_lock, inv_hit_ll, ev_hit_lock;

   always_comb begin
      inv_hit_lock = 1'b0;
      inv_hit_ll   = 1'b0;
      for (int i = 0; i < NUM_SNOOP; i++) begin
         if (inv_valid[i] && ((inv_addr[i*ADDR_W +: ADDR_W] & MSK) == resv_blk))
            inv_hit_lock = 1'b1;
         if (inv_valid[i] && ((inv_addr[i*ADDR_W +: ADDR_W] & MSK) == (ll_addr & MSK)))
            inv_hit_ll = 1'b1;
      end
      ev_hit_lock = evict_valid && (!EVICT_BY_ADDR || ((evict_addr & MSK) == resv_blk));
   end

   a_r2_ll_loads_block: assert property (@(posedge clk) disable iff (!rst_n)
      ll_valid |=> resv_blk == ($past(ll_addr) & MSK));

   a_r4_pass_needs_resv: assert property (@(posedge clk) disable iff (!rst_n)
      sc_pass |-> (resv_flag && ((sc_addr & MSK) == resv_blk)));

   a_r5_sc_consumes: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_valid && !ll_valid) |=> !resv_flag);

   a_r6_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_hit_lock && !ll_valid) |=> !resv_flag);

   a_r7_inv_beats_sc: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_valid && inv_hit_lock) |-> !sc_pass);

   a_r8_evict_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_hit_lock && !ll_valid) |=> !resv_flag);

   a_r9_ll_killed: assert property (@(posedge clk) disable iff (!rst_n)
      (ll_valid && inv_hit_ll) |=> !resv_flag);

   a_r10_no_verdict_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !sc_valid |-> (!sc_done && !sc_pass));
endmodule

bind llsc_resv_monitor llsc_resv_checker #(
   .ADDR_W        (ADDR_W),
   .BLOCK_BYTES   (BLOCK_BYTES),
   .NUM_SNOOP     (NUM_SNOOP),
   .EVICT_BY_ADDR (EVICT_BY_ADDR)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ll_valid    (ll_valid),
   .ll_addr     (ll_addr),
   .sc_valid    (sc_valid),
   .sc_addr     (sc_addr),
   .inv_valid   (inv_valid),
   .inv_addr    (inv_addr),
   .evict_valid (evict_valid),
   .evict_addr  (evict_addr),
   .sc_done     (sc_done),
   .sc_pass     (sc_pass),
   .resv_flag   (resv_flag),
   .resv_blk    (resv_blk)
);

// File: tb/sim_llsc_resv_monitor.sv
`timescale 1ns/1ps
module sim_llsc_resv_monitor;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        ll_valid, sc_valid, evict_valid;
   logic [31:0] ll_addr, sc_addr, evict_addr;
   logic [1:0]  inv_valid;
   logic [63:0] inv_addr;
   logic        sc_done, sc_pass;

   int n_chk  = 0;
   int n_fail = 0;
   bit reported = 0;

   always #4 clk = ~clk;

   llsc_resv_monitor u0 (
      .clk(clk), .rst_n(rst_n),
      .ll_valid(ll_valid), .ll_addr(ll_addr),
      .sc_valid(sc_valid), .sc_addr(sc_addr),
      .inv_valid(inv_valid), .inv_addr(inv_addr),
      .evict_valid(evict_valid), .evict_addr(evict_addr),
      .sc_done(sc_done), .sc_pass(sc_pass)
   );

   localparam logic [31:0] A = 32'h0000_1000;
   localparam logic [31:0] B = 32'h0000_2000;

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      end
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle_inputs();
      ll_valid = 0; ll_addr = '0; sc_valid = 0; sc_addr = '0;
      inv_valid = '0; inv_addr = '0; evict_valid = 0; evict_addr = '0;
   endtask

   // One cycle of stimulus: drive at falling edge, sample verdict 1 ns later.
   task automatic step(input logic ll, input logic [31:0] la,
                       input logic sc, input logic [31:0] sa,
                       input logic [1:0] iv, input logic [31:0] i0, input logic [31:0] i1,
                       input logic ev, input logic [31:0] ea,
                       output logic done, output logic pass);
      @(negedge clk);
      ll_valid = ll; ll_addr = la; sc_valid = sc; sc_addr = sa;
      inv_valid = iv; inv_addr = {i1, i0}; evict_valid = ev; evict_addr = ea;
      #1;
      done = sc_done; pass = sc_pass;
      @(posedge clk);
      #1;
      idle_inputs();
   endtask

   task automatic do_ll(input logic [31:0] a);
      logic d, p;
      step(1, a, 0, 0, 2'b00, 0, 0, 0, 0, d, p);
   endtask

   task automatic do_sc(input string req, input logic [31:0] a, input logic exp);
      logic d, p;
      step(0, 0, 1, a, 2'b00, 0, 0, 0, 0, d, p);
      chk({req, " sc_done"}, d, 1'b1);
      chk({req, " sc_pass"}, p, exp);
   endtask

   task automatic do_inv(input logic [1:0] iv, input logic [31:0] i0, input logic [31:0] i1);
      logic d, p;
      step(0, 0, 0, 0, iv, i0, i1, 0, 0, d, p);
   endtask

   task automatic t_reset();
      logic d, p;
      step(0, 0, 0, 0, 2'b00, 0, 0, 0, 0, d, p);
      chk("R10 idle sc_done", d, 1'b0);
      chk("R10 idle sc_pass", p, 1'b0);
      do_sc("R1 sc after reset", A, 1'b0);
   endtask

   task automatic t_basic();
      do_ll(A);
      do_sc("R2 R4 ll then sc", A, 1'b1);
   endtask

   task automatic t_granularity();
      do_ll(32'h1004);
      do_sc("R3 same block offsets", 32'h103C, 1'b1);
      do_ll(32'h1000);
      do_sc("R3 next block", 32'h1040, 1'b0);
   endtask

   task automatic t_consume();
      do_ll(A);
      do_sc("R5 first sc", A, 1'b1);
      do_sc("R5 second sc", A, 1'b0);
      do_ll(A);
      do_sc("R5 wrong block sc", B, 1'b0);
      do_sc("R5 after failed sc", A, 1'b0);
   endtask

   task automatic t_snoop();
      do_ll(A);
      do_inv(2'b01, 32'h1008, 0);
      do_sc("R6 inv chan0", A, 1'b0);
      do_ll(A);
      do_inv(2'b10, 0, 32'h1030);
      do_sc("R6 inv chan1", A, 1'b0);
      do_ll(A);
      do_inv(2'b11, B, 32'h1040);
      do_sc("R6 other blocks ignored", A, 1'b1);
      do_ll(A);
      do_inv(2'b00, A, A);
      do_sc("R6 invalid snoop ignored", A, 1'b1);
   endtask

   task automatic t_coincide();
      logic d, p;
      do_ll(A);
      step(0, 0, 1, A, 2'b01, A, 0, 0, 0, d, p);
      chk("R7 inv with sc done", d, 1'b1);
      chk("R7 inv with sc pass", p, 1'b0);
      do_sc("R7 after coincident", A, 1'b0);
      do_ll(A);
      step(0, 0, 1, A, 2'b10, 0, 32'h3000, 0, 0, d, p);
      chk("R7 unrelated inv with sc", p, 1'b1);
   endtask

   task automatic t_evict();
      logic d, p;
      do_ll(A);
      step(0, 0, 0, 0, 2'b00, 0, 0, 1, 32'h1010, d, p);
      do_sc("R8 evict locked block", A, 1'b0);
      do_ll(A);
      step(0, 0, 0, 0, 2'b00, 0, 0, 1, 32'h5000, d, p);
      do_sc("R8 evict other block", A, 1'b1);
   endtask

   task automatic t_ll_priority();
      logic d, p;
      do_ll(A);
      do_ll(B);
      do_sc("R9 old block after new ll", A, 1'b0);
      do_ll(A);
      do_ll(B);
      do_sc("R9 new block", B, 1'b1);
      step(1, A, 0, 0, 2'b01, 32'h1020, 0, 0, 0, d, p);
      do_sc("R9 ll killed same cycle", A, 1'b0);
      do_ll(A);
      step(1, B, 1, A, 2'b00, 0, 0, 0, 0, d, p);
      chk("R9 sc with ll judged old", p, 1'b1);
      do_sc("R9 ll survives sc", B, 1'b1);
   endtask

   initial begin
      idle_inputs();
      rst_n = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      t_reset();
      t_basic();
      t_granularity();
      t_consume();
      t_snoop();
      t_coincide();
      t_evict();
      t_ll_priority();
      repeat (2) @(posedge clk);
      report();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
   end
endmodule